// File: doc/BRIEF.md
# Translation-Service Inbound Message Router

This block sits on the receive side of a host-link adapter and takes the two incoming AXI4-Stream channels that carry address-translation traffic from the host's translation agent. The host-request stream brings invalidation requests and page-request responses. The completion stream brings translation completions that answer lookups sent out earlier. Each message is one or more beats, and the last beat carries a last marker.

The router decodes the message type from the low nibble of the first beat. It then steers the whole message, beat by beat and with no added latency, to one of three consumer ports: translation fill, invalidation, or page-request response. Foreign message types are consumed and thrown away at full rate, so unrelated traffic can never stall a stream.

Each stream has its own byte-parity check, which can be turned on or off. It also has a sticky parity-error flag and a saturating count of discarded messages. The two streams are fully independent lanes, so they can deliver, stall and discard in the same cycle without affecting each other.

Top module: `xlat_inbound_router`

## Requirements
- R1: While reset is held and in the first cycle after it, every consumer valid is low, both discard counters read zero and both sticky parity flags are clear.
- R2: On the host-request stream, a message whose first beat has type code 4'h1 in data bits [3:0] goes to the invalidation port. Code 4'h2 goes to the page-response port. Every beat up to and including the one with last set goes to that same port, with data and last unchanged.
- R3: On the completion stream, a message whose first-beat type code in data bits [3:0] is 4'h4 goes to the fill port, beat for beat, with data and last unchanged.
- R4: A message with any other type code is discarded. The stream's ready stays high on every one of its beats, and no consumer valid is raised.
- R5: When a stream's parity enable is high, parity bit i of that stream must give even parity over data byte i, meaning the XOR of bits [8i+7:8i] and parity bit i is zero. A first beat that breaks this causes the whole message to be discarded as in R4. When the enable is low, parity is ignored.
- R6: If a parity error appears on a later beat of a message already being delivered, that beat is delivered with last=1 and abort=1. The remaining beats of that input message are then discarded.
- R7: Each stream has a sticky flag that is set by any accepted beat with a parity error (enable high). It stays set until reset.
- R8: Each stream has a 16-bit discard counter. It adds one per discarded message: a foreign type, a first-beat parity error, or a message cut short as in R6. It saturates at 65535.
- R9: When a beat is steered to a consumer whose ready is low, the stream's ready is low and the beat is held. Only the stream that is steered to that consumer is held back.
- R10: Both streams can deliver, discard or stall in the same cycle, each exactly as it would alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_en_hreq | input | 1 | Parity check enable, host-request stream |
| par_en_cpl | input | 1 | Parity check enable, completion stream |
| hreq_valid | input | 1 | Host-request beat valid |
| hreq_ready | output | 1 | Host-request beat accepted |
| hreq_data | input | DATA_W | Host-request beat data |
| hreq_par | input | DATA_W/8 | Host-request byte parity |
| hreq_last | input | 1 | Host-request last beat of message |
| cpl_valid | input | 1 | Completion beat valid |
| cpl_ready | output | 1 | Completion beat accepted |
| cpl_data | input | DATA_W | Completion beat data |
| cpl_par | input | DATA_W/8 | Completion byte parity |
| cpl_last | input | 1 | Completion last beat of message |
| inv_valid | output | 1 | Invalidation port valid |
| inv_ready | input | 1 | Invalidation port ready |
| inv_data | output | DATA_W | Invalidation port data |
| inv_last | output | 1 | Invalidation port last |
| inv_abort | output | 1 | Invalidation message cut short by parity error |
| prr_valid | output | 1 | Page-response port valid |
| prr_ready | input | 1 | Page-response port ready |
| prr_data | output | DATA_W | Page-response port data |
| prr_last | output | 1 | Page-response port last |
| prr_abort | output | 1 | Page-response message cut short by parity error |
| fill_valid | output | 1 | Translation-fill port valid |
| fill_ready | input | 1 | Translation-fill port ready |
| fill_data | output | DATA_W | Translation-fill port data |
| fill_last | output | 1 | Translation-fill port last |
| fill_abort | output | 1 | Fill message cut short by parity error |
| hreq_perr_sticky | output | 1 | Sticky parity error, host-request stream |
| cpl_perr_sticky | output | 1 | Sticky parity error, completion stream |
| hreq_drop_cnt | output | CNT_W | Discarded messages, host-request stream |
| cpl_drop_cnt | output | CNT_W | Discarded messages, completion stream |

## Verification
The overlap of interest is one stream delivering, or being held by a busy consumer, while the other stream discards a foreign or errored message in the same cycle. The reverse case matters too: both streams handing beats to their consumers at once. Both streams are driven together with random gaps, random consumer readies, mixed type codes and parity errors injected on first and later beats. A behavioural model of each stream predicts every valid, ready, data, last, abort, flag and counter on every clock, and the bench also confirms that cycles with two deliveries at once really took place.

// File: rtl/xir_pkg.sv
`timescale 1ns/1ps
// Package xir_pkg
// Shared constants for the inbound translation-service router: width of the
// type field at the bottom of the first beat and the codes it may carry.
package xir_pkg;
    localparam int unsigned TYPE_W = 4;
    localparam logic [TYPE_W-1:0] MT_INVAL = 4'h1;  // invalidation request
    localparam logic [TYPE_W-1:0] MT_PGRSP = 4'h2;  // page-request response
    localparam logic [TYPE_W-1:0] MT_XLCPL = 4'h4;  // translation completion
endpackage

// File: rtl/xir_byte_parity.sv
`timescale 1ns/1ps
// Module xir_byte_parity
// Checks even parity of every data byte against its sideband bit.
// Assumes DATA_W is a multiple of 8. Output is purely combinational;
// with en low the error output is forced low.
module xir_byte_parity #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned NB = DATA_W / 8
) (
    input  logic              en,
    input  logic [DATA_W-1:0] data,
    input  logic [NB-1:0]     par,
    output logic              err
);
    logic [NB-1:0] bad;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        // one byte: XOR of data bits and parity bit must be zero
        assign bad[b] = ^{data[b*8 +: 8], par[b]};
    end

    // any failing byte flags the beat when checking is on
    assign err = en & (|bad);
endmodule

// File: rtl/xir_lane.sv
`timescale 1ns/1ps
// Module xir_lane
// One inbound stream: decodes the first-beat type, steers the message to one
// of N_OUT consumers in cut-through fashion, discards foreign or first-beat
// errored messages at full rate, truncates a delivered message with an abort
// beat on a later parity error, and keeps a sticky error flag and a
// saturating discard count. Assumes the source holds a beat until accepted.
module xir_lane #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_OUT  = 2,
    parameter int unsigned TYPE_W = 4,
    parameter logic [N_OUT*TYPE_W-1:0] CODES = '0,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned NB    = DATA_W / 8,
    localparam int unsigned SEL_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [NB-1:0]     in_par,
    input  logic              in_last,
    output logic [N_OUT-1:0]  out_valid,
    input  logic [N_OUT-1:0]  out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_abort,
    output logic              perr_sticky,
    output logic [CNT_W-1:0]  drop_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             mid_q;    // inside a message (after first beat)
    logic             drop_q;   // rest of current message is discarded
    logic [SEL_W-1:0] sel_q;    // consumer of current message
    logic             stk_q;
    logic [CNT_W-1:0] cnt_q;

    logic             perr;
    logic             hit;
    logic [SEL_W-1:0] hit_idx;
    logic             first;
    logic [SEL_W-1:0] tgt;
    logic             drop;
    logic             tgt_rdy;
    logic             acc;
    logic             cnt_inc;

    xir_byte_parity #(.DATA_W(DATA_W)) u_par (
        .en   (par_en),
        .data (in_data),
        .par  (in_par),
        .err  (perr)
    );

    // match the first-beat type field against the consumer codes
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < int'(N_OUT); i++) begin
            if (in_data[TYPE_W-1:0] == CODES[i*TYPE_W +: TYPE_W]) begin
                hit     = 1'b1;
                hit_idx = SEL_W'(i);
            end
        end
    end

    assign first = ~mid_q;
    assign tgt   = first ? hit_idx : sel_q;
    assign drop  = first ? (~hit | perr) : drop_q;

    // ready of the selected consumer
    always_comb begin
        tgt_rdy = 1'b0;
        for (int i = 0; i < int'(N_OUT); i++) begin
            if (tgt == SEL_W'(i)) tgt_rdy = out_ready[i];
        end
    end

    // steer the beat to its consumer; discarded beats never wait
    always_comb begin
        for (int i = 0; i < int'(N_OUT); i++) begin
            out_valid[i] = in_valid & ~drop & (tgt == SEL_W'(i));
        end
    end

    assign in_ready  = drop | tgt_rdy;
    assign out_data  = in_data;
    assign out_last  = in_last | perr;
    assign out_abort = perr;

    assign acc     = in_valid & in_ready;
    assign cnt_inc = (first & drop) | (~drop & perr);

    // message tracking, sticky error and discard counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_q  <= 1'b0;
            drop_q <= 1'b0;
            sel_q  <= '0;
            stk_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (acc) begin
            if (perr) stk_q <= 1'b1;
            if (cnt_inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (in_last) begin
                mid_q  <= 1'b0;
                drop_q <= 1'b0;
            end else begin
                mid_q  <= 1'b1;
                sel_q  <= tgt;
                drop_q <= drop | perr;
            end
        end
    end

    assign perr_sticky = stk_q;
    assign drop_cnt    = cnt_q;

    // at most one consumer sees a beat
    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    // a foreign first beat is swallowed without touching any consumer
    p_foreign_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mid_q && !hit) |-> (in_ready && out_valid == '0));

    // a cut-short beat always closes the message
    p_abort_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid && out_abort) |-> out_last);

    // sticky flag never clears outside reset
    p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q |=> stk_q);

    // saturated counter stays saturated
    p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    // a stalled consumer holds back the stream
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid & ~out_ready) != '0) |-> !in_ready);
endmodule

// File: rtl/xlat_inbound_router.sv
`timescale 1ns/1ps
// Module xlat_inbound_router
// Receives the host-request and completion streams of the translation
// service and hands their messages to the invalidation, page-response and
// translation-fill consumers. The two streams are independent lanes; any
// type outside a lane's code list is discarded without back-pressure.
module xlat_inbound_router
    import xir_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned NB    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_en_hreq,
    input  logic              par_en_cpl,
    input  logic              hreq_valid,
    output logic              hreq_ready,
    input  logic [DATA_W-1:0] hreq_data,
    input  logic [NB-1:0]     hreq_par,
    input  logic              hreq_last,
    input  logic              cpl_valid,
    output logic              cpl_ready,
    input  logic [DATA_W-1:0] cpl_data,
    input  logic [NB-1:0]     cpl_par,
    input  logic              cpl_last,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic [DATA_W-1:0] inv_data,
    output logic              inv_last,
    output logic              inv_abort,
    output logic              prr_valid,
    input  logic              prr_ready,
    output logic [DATA_W-1:0] prr_data,
    output logic              prr_last,
    output logic              prr_abort,
    output logic              fill_valid,
    input  logic              fill_ready,
    output logic [DATA_W-1:0] fill_data,
    output logic              fill_last,
    output logic              fill_abort,
    output logic              hreq_perr_sticky,
    output logic              cpl_perr_sticky,
    output logic [CNT_W-1:0]  hreq_drop_cnt,
    output logic [CNT_W-1:0]  cpl_drop_cnt
);
    logic [1:0]        hq_vld;
    logic [DATA_W-1:0] hq_data;
    logic              hq_last;
    logic              hq_abort;

    // host-request lane: index 0 = invalidation, index 1 = page response
    xir_lane #(
        .DATA_W (DATA_W),
        .N_OUT  (2),
        .TYPE_W (TYPE_W),
        .CODES  ({MT_PGRSP, MT_INVAL}),
        .CNT_W  (CNT_W)
    ) u_hreq (
        .clk         (clk),
        .rst_n       (rst_n),
        .par_en      (par_en_hreq),
        .in_valid    (hreq_valid),
        .in_ready    (hreq_ready),
        .in_data     (hreq_data),
        .in_par      (hreq_par),
        .in_last     (hreq_last),
        .out_valid   (hq_vld),
        .out_ready   ({prr_ready, inv_ready}),
        .out_data    (hq_data),
        .out_last    (hq_last),
        .out_abort   (hq_abort),
        .perr_sticky (hreq_perr_sticky),
        .drop_cnt    (hreq_drop_cnt)
    );

    assign inv_valid = hq_vld[0];
    assign prr_valid = hq_vld[1];
    assign inv_data  = hq_data;
    assign prr_data  = hq_data;
    assign inv_last  = hq_last;
    assign prr_last  = hq_last;
    assign inv_abort = hq_abort;
    assign prr_abort = hq_abort;

    // completion lane: single consumer, the translation fill port
    xir_lane #(
        .DATA_W (DATA_W),
        .N_OUT  (1),
        .TYPE_W (TYPE_W),
        .CODES  (MT_XLCPL),
        .CNT_W  (CNT_W)
    ) u_cpl (
        .clk         (clk),
        .rst_n       (rst_n),
        .par_en      (par_en_cpl),
        .in_valid    (cpl_valid),
        .in_ready    (cpl_ready),
        .in_data     (cpl_data),
        .in_par      (cpl_par),
        .in_last     (cpl_last),
        .out_valid   (fill_valid),
        .out_ready   (fill_ready),
        .out_data    (fill_data),
        .out_last    (fill_last),
        .out_abort   (fill_abort),
        .perr_sticky (cpl_perr_sticky),
        .drop_cnt    (cpl_drop_cnt)
    );
endmodule

// File: tb/xlat_inbound_router_test.sv
`timescale 1ns/1ps
// Bench for xlat_inbound_router: drives both streams from message queues and
// compares every output against a behavioural per-stream model each clock.
module xlat_inbound_router_test;
    typedef struct packed {
        logic [31:0] d;
        logic [3:0]  p;
        logic        l;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        par_en_hreq, par_en_cpl;
    logic        hreq_valid, hreq_ready, hreq_last;
    logic [31:0] hreq_data;
    logic [3:0]  hreq_par;
    logic        cpl_valid, cpl_ready, cpl_last;
    logic [31:0] cpl_data;
    logic [3:0]  cpl_par;
    logic        inv_valid, inv_ready, inv_last, inv_abort;
    logic [31:0] inv_data;
    logic        prr_valid, prr_ready, prr_last, prr_abort;
    logic [31:0] prr_data;
    logic        fill_valid, fill_ready, fill_last, fill_abort;
    logic [31:0] fill_data;
    logic        hreq_perr_sticky, cpl_perr_sticky;
    logic [15:0] hreq_drop_cnt, cpl_drop_cnt;

    always #4 clk = ~clk;

    xlat_inbound_router uut (.*);

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int both_deliver = 0;

    beat_t qs[2][$];
    bit    vcur[2];
    bit    acc[2];
    bit    gaps;
    bit    rdy_rand;

    bit    m_mid[2];
    int    m_sel[2];
    bit    m_dr[2];
    int    m_cnt[2];
    bit    m_stk[2];

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] epar(logic [31:0] d);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = ^d[i*8 +: 8];
        return r;
    endfunction

    function automatic int dec(int l, logic [3:0] c);
        if (l == 0) begin
            if (c == 4'h1) return 0;
            if (c == 4'h2) return 1;
            return -1;
        end
        if (c == 4'h4) return 0;
        return -1;
    endfunction

    task automatic add_msg(int l, logic [3:0] code, int nb, int errb);
        for (int b = 0; b < nb; b++) begin
            beat_t x;
            x.d = $urandom;
            if (b == 0) x.d[3:0] = code;
            x.p = epar(x.d);
            if (b == errb) x.p[0] = ~x.p[0];
            x.l = (b == nb - 1);
            qs[l].push_back(x);
        end
    endtask

    // present beats and consumer readies just after the clock edge
    task automatic drive();
        for (int l = 0; l < 2; l++) begin
            if (acc[l]) void'(qs[l].pop_front());
            if (!(vcur[l] && !acc[l]))
                vcur[l] = (qs[l].size() > 0) && (!gaps || ($urandom % 4 != 0));
        end
        hreq_valid = vcur[0];
        {hreq_data, hreq_par, hreq_last} = vcur[0] ? qs[0][0] : '0;
        cpl_valid = vcur[1];
        {cpl_data, cpl_par, cpl_last} = vcur[1] ? qs[1][0] : '0;
        inv_ready  = rdy_rand ? ($urandom % 4 != 0) : 1'b1;
        prr_ready  = rdy_rand ? ($urandom % 4 != 0) : 1'b1;
        fill_ready = rdy_rand ? ($urandom % 4 != 0) : 1'b1;
    endtask

    // compare one stream against the model, then advance the model
    task automatic eval_lane(int l);
        logic v, lst, en, ard, astk, perr, first, drop, erdy;
        logic [31:0] d;
        logic [3:0]  p;
        logic [1:0]  rdy, av, eav;
        logic [31:0] adata;
        logic        alast, aabort;
        logic [15:0] acnt;
        int t;
        string tag;
        if (l == 0) begin
            v = hreq_valid; d = hreq_data; p = hreq_par; lst = hreq_last;
            en = par_en_hreq; rdy = {prr_ready, inv_ready};
            av = {prr_valid, inv_valid}; ard = hreq_ready;
            astk = hreq_perr_sticky; acnt = hreq_drop_cnt;
        end else begin
            v = cpl_valid; d = cpl_data; p = cpl_par; lst = cpl_last;
            en = par_en_cpl; rdy = {1'b0, fill_ready};
            av = {1'b0, fill_valid}; ard = cpl_ready;
            astk = cpl_perr_sticky; acnt = cpl_drop_cnt;
        end
        perr  = en && (p != epar(d));
        first = !m_mid[l];
        t     = first ? dec(l, d[3:0]) : m_sel[l];
        drop  = first ? (t < 0 || perr) : m_dr[l];
        if (perr) tag = first ? "R5" : "R6";
        else if (drop) tag = "R4";
        else tag = (l == 0) ? "R2" : "R3";
        if (!en && p != epar(d) && v) tag = "R5";
        eav = (v && !drop) ? (2'b01 << t) : 2'b00;
        chk(av == eav, tag, "consumer valid", av, eav);
        erdy = drop ? 1'b1 : rdy[t];
        if (v) chk(ard == erdy, drop ? "R4" : "R9", "stream ready", ard, erdy);
        if (v && !drop) begin
            if (l == 1) begin
                adata = fill_data; alast = fill_last; aabort = fill_abort;
            end else if (t == 0) begin
                adata = inv_data; alast = inv_last; aabort = inv_abort;
            end else begin
                adata = prr_data; alast = prr_last; aabort = prr_abort;
            end
            chk(adata == d, tag, "data", adata, d);
            chk(alast == (lst | perr), tag, "last", alast, lst | perr);
            chk(aabort == perr, perr ? "R6" : tag, "abort", aabort, perr);
        end
        chk(astk == m_stk[l], "R7", "sticky", astk, m_stk[l]);
        chk(int'(acnt) == m_cnt[l], "R8", "drop count", acnt, m_cnt[l]);
        acc[l] = v && erdy;
        if (acc[l]) begin
            if (perr) m_stk[l] = 1'b1;
            if (((first && drop) || (!drop && perr)) && m_cnt[l] < 65535) m_cnt[l]++;
            if (lst) begin
                m_mid[l] = 1'b0;
                m_dr[l]  = 1'b0;
            end else begin
                m_mid[l] = 1'b1;
                m_sel[l] = t;
                m_dr[l]  = drop || perr;
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        drive();
        @(negedge clk);
        if ((inv_valid || prr_valid) && fill_valid) both_deliver++;
        eval_lane(0);
        eval_lane(1);
    endtask

    task automatic run_all();
        while (qs[0].size() > 0 || qs[1].size() > 0) step();
        step();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // watchdog: a hung run ends as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            failures++;
            $display("FAIL watchdog all-requirements act=%0d exp<190000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0] hcodes[7] = '{4'h1, 4'h2, 4'h1, 4'h2, 4'h3, 4'h0, 4'hF};
        logic [3:0] ccodes[5] = '{4'h4, 4'h4, 4'h4, 4'h5, 4'h0};
        rst_n = 1'b0;
        par_en_hreq = 1'b1;
        par_en_cpl  = 1'b1;
        hreq_valid = 1'b0; hreq_data = '0; hreq_par = '0; hreq_last = 1'b0;
        cpl_valid  = 1'b0; cpl_data  = '0; cpl_par  = '0; cpl_last  = 1'b0;
        inv_ready = 1'b1; prr_ready = 1'b1; fill_ready = 1'b1;
        gaps = 1'b0; rdy_rand = 1'b0;
        for (int l = 0; l < 2; l++) begin
            vcur[l] = 0; acc[l] = 0; m_mid[l] = 0; m_sel[l] = 0;
            m_dr[l] = 0; m_cnt[l] = 0; m_stk[l] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: state while reset is held
        chk(hreq_drop_cnt == 0 && cpl_drop_cnt == 0, "R1", "counters in reset",
            {hreq_drop_cnt, cpl_drop_cnt}, 0);
        chk(!hreq_perr_sticky && !cpl_perr_sticky, "R1", "sticky in reset",
            {hreq_perr_sticky, cpl_perr_sticky}, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!inv_valid && !prr_valid && !fill_valid, "R1", "valids after reset",
            {inv_valid, prr_valid, fill_valid}, 0);
        chk(hreq_drop_cnt == 0 && cpl_drop_cnt == 0 && !hreq_perr_sticky && !cpl_perr_sticky,
            "R1", "status after reset", {hreq_drop_cnt, cpl_drop_cnt}, 0);

        // directed: both streams deliver together, all consumers ready (R10)
        add_msg(0, 4'h1, 2, -1);
        add_msg(1, 4'h4, 2, -1);
        add_msg(0, 4'h2, 3, -1);
        add_msg(1, 4'h7, 3, -1);
        run_all();
        chk(both_deliver >= 2, "R10", "same-cycle deliveries", both_deliver, 2);

        // mixed traffic with gaps, back-pressure and parity errors
        gaps = 1'b1; rdy_rand = 1'b1;
        for (int i = 0; i < 250; i++) begin
            int nb0 = 1 + $urandom % 4;
            int nb1 = 1 + $urandom % 4;
            add_msg(0, hcodes[$urandom % 7], nb0, ($urandom % 5 == 0) ? int'($urandom % nb0) : -1);
            add_msg(1, ccodes[$urandom % 5], nb1, ($urandom % 5 == 0) ? int'($urandom % nb1) : -1);
        end
        run_all();
        chk(both_deliver > 10, "R10", "overlap occurred", both_deliver, 10);
        chk(hreq_perr_sticky && cpl_perr_sticky, "R7", "sticky set by traffic",
            {hreq_perr_sticky, cpl_perr_sticky}, 2'b11);
        chk(hreq_drop_cnt > 0 && cpl_drop_cnt > 0, "R4", "foreign messages counted",
            hreq_drop_cnt, 1);

        // parity disabled: bad parity is ignored
        par_en_hreq = 1'b0; par_en_cpl = 1'b0;
        for (int i = 0; i < 40; i++) begin
            add_msg(0, (i % 2) ? 4'h1 : 4'h2, 2, 0);
            add_msg(1, 4'h4, 2, 1);
        end
        run_all();
        chk(1'(hreq_perr_sticky) == m_stk[0], "R5", "sticky with check off",
            hreq_perr_sticky, m_stk[0]);
        par_en_hreq = 1'b1; par_en_cpl = 1'b1;

        // saturation of the completion-stream discard counter
        gaps = 1'b0; rdy_rand = 1'b0;
        for (int i = 0; i < 65540; i++) add_msg(1, 4'h0, 1, -1);
        add_msg(0, 4'h3, 1, -1);
        run_all();
        chk(cpl_drop_cnt == 16'hFFFF, "R8", "saturated count", cpl_drop_cnt, 16'hFFFF);
        add_msg(1, 4'h9, 2, -1);
        run_all();
        chk(cpl_drop_cnt == 16'hFFFF, "R8", "count stays saturated", cpl_drop_cnt, 16'hFFFF);

        summary();
        $finish;
    end
endmodule